// File: doc/BRIEF.md
# Interrupt distributor register bank

This block holds the configuration state of the shared peripheral interrupts of an interrupt distributor. Each implemented interrupt has a group bit, an enable bit, a pending bit, an active bit, an 8-bit priority, a 2-bit trigger configuration and a 2-bit non-secure access field. It also has a small control register and a read-only type register. Software reaches all of this through a simple register port that carries an address, write data, a byte count (1, 2 or 4) and a flag that marks the access as secure. Every per-interrupt field is also driven out as a vector to the selection logic downstream.

Interrupt IDs 32 up to `NUM_LINES-1` are implemented. Bit `k` of each output vector, or field `k` of each wide vector, belongs to ID `32+k`. While security is enabled (security-disable bit clear), a non-secure access cannot see group-0 interrupts. It also sees priorities through a one-bit shifted view. Reads are combinational. Writes take effect at the rising clock edge where `req_i && we_i` is high.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset, all per-interrupt state and all control enables are zero. The control register at offset 0x000 reads 0x10.
- R2: The type register at offset 0x004 reads `(ceil(NUM_LINES/32)-1)` in bits [4:0] and ones in bits 16 and 17, which gives 0x30002 for 96 lines. Writes to it are ignored.
- R3: The one-bit-per-ID registers are set-enable 0x100, clear-enable 0x180, set-pending 0x200, clear-pending 0x280, set-active 0x300 and clear-active 0x380. Data bit i of the word at base+4n maps to ID 32n+i. Writing 1 performs the action, writing 0 does nothing, and a read of either register of a pair returns the current state. A byte count of 1 or 2 limits the access to data bits [7:0] or [15:0].
- R4: Priority is one byte per ID at offset 0x400+ID, and data byte i goes to ID (offset-0x400)+i for i below the byte count.
- R5: While security is enabled, a non-secure priority write stores 0x80 | (value>>1), and a non-secure priority read returns (stored<<1)&0xFF. Secure accesses, and any access with security disabled, use the value unchanged.
- R6: Trigger configuration (0xC00) and non-secure access control (0xD00) use two bits per ID. Data bits [2i+1:2i] of the word at base+4n map to ID 16n+i. The access control field reads zero and ignores writes when security is disabled or the access is non-secure.
- R7: The group register at 0x080 (1 = non-secure group) reads zero and ignores writes for non-secure accesses while security is enabled. In the same state, every per-interrupt field of a group-0 ID reads zero and ignores writes from non-secure accesses.
- R8: The control register has group-0 enable in bit 0, non-secure group-1 enable in bit 1, secure group-1 enable in bit 2, routing-enable in bit 4 (it always reads 1, and writing 0 is ignored) and security-disable in bit 6, which only secure writes change. While security is enabled, a non-secure access reads and writes only bit 1 and sees bit 4.
- R9: A write to offset 0x010 sets, and a write to 0x014 clears, the pending bit of the ID in data bits [9:0], subject to R7 and R11. Both offsets read zero.
- R10: Legacy target offsets 0x800–0xBFF, the software-interrupt pending offsets 0xF10–0xF2F and every undecoded offset read zero and ignore writes.
- R11: IDs below 32 and at or above `NUM_LINES` read zero and ignore writes in every per-interrupt register.
- R12: Per-interrupt and control state changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| size_i | input | 3 | Byte count: 1, 2 or 4 |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is secure |
| rdata_o | output | 32 | Read data, zero when no read is requested |
| grp_o | output | NUM_LINES-32 | Group bit per ID |
| en_o | output | NUM_LINES-32 | Enable per ID |
| pend_o | output | NUM_LINES-32 | Pending per ID |
| act_o | output | NUM_LINES-32 | Active per ID |
| prio_o | output | 8*(NUM_LINES-32) | Stored priority per ID |
| cfg_o | output | 2*(NUM_LINES-32) | Trigger configuration per ID |
| nsac_o | output | 2*(NUM_LINES-32) | Non-secure access control per ID |
| sec_dis_o | output | 1 | Security disabled |
| en_grp0_o | output | 1 | Group-0 enable |
| en_grp1ns_o | output | 1 | Non-secure group-1 enable |
| en_grp1s_o | output | 1 | Secure group-1 enable |

## Verification
Some properties are checked on every cycle. The routing-enable bit always reads as one, and the legacy region reads zero. Non-secure reads of the access-control field return zero. Set-enable writes never clear a bit, clear-enable writes never set one, and state holds whenever no write is made. A non-secure priority write to a visible ID always leaves the top bit set. Other behaviour is only shown by the bench's scenarios, compared against its behavioural model. That covers hiding of group-0 IDs, the exact shifted priority values, byte-count limits, the single-ID pending ports, the out-of-range IDs and the change in behaviour once security is disabled.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 12;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_SPEND_ID, RG_CPEND_ID,
    RG_GROUP, RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR,
    RG_AC_SET, RG_AC_CLR, RG_PRIO, RG_CFG, RG_NSAC
  } region_e;
endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ID_W-1:0]   first_id_o
);
  always_comb begin
    region_o   = RG_NONE;
    first_id_o = '0;
    if (addr_i == 12'h000)      region_o = RG_CTRL;
    else if (addr_i == 12'h004) region_o = RG_TYPE;
    else if (addr_i == 12'h010) region_o = RG_SPEND_ID;
    else if (addr_i == 12'h014) region_o = RG_CPEND_ID;
    else if (addr_i[11:10] == 2'b00 && addr_i[9:7] != 3'b000) begin
      first_id_o = {2'b00, addr_i[6:0], 3'b000};
      case (addr_i[9:7])
        3'd1:    region_o = RG_GROUP;
        3'd2:    region_o = RG_EN_SET;
        3'd3:    region_o = RG_EN_CLR;
        3'd4:    region_o = RG_PD_SET;
        3'd5:    region_o = RG_PD_CLR;
        3'd6:    region_o = RG_AC_SET;
        default: region_o = RG_AC_CLR;
      endcase
    end else if (addr_i[11:10] == 2'b01) begin
      region_o   = RG_PRIO;
      first_id_o = {2'b00, addr_i[9:0]};
    end else if (addr_i[11:8] == 4'hC) begin
      region_o   = RG_CFG;
      first_id_o = {2'b00, addr_i[7:0], 2'b00};
    end else if (addr_i[11:8] == 4'hD) begin
      region_o   = RG_NSAC;
      first_id_o = {2'b00, addr_i[7:0], 2'b00};
    end
    // legacy target, software-interrupt pending and holes: RG_NONE (RAZ/WI)
  end
endmodule

// File: rtl/irq_dist_slice.sv
module irq_dist_slice
  import irq_dist_pkg::*;
#(
  parameter int ID = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            sec_i,
  input  logic            ds_i,
  input  region_e         region_i,
  input  logic [ID_W-1:0] first_id_i,
  input  logic [5:0]      nbits_i,
  input  logic [2:0]      nbytes_i,
  input  logic [31:0]     wdata_i,
  output logic            grp_o,
  output logic            en_o,
  output logic            pend_o,
  output logic            act_o,
  output logic [7:0]      prio_o,
  output logic [1:0]      cfg_o,
  output logic [1:0]      nsac_o,
  output logic [31:0]     rdata_o
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(ID);

  logic [ID_W-1:0] off;
  logic ge, in_bits, in_pair, in_byte, id_hit;
  logic vis, ns_xf, grp_ok, nsac_ok, wbit;
  logic [1:0] wpair;
  logic [7:0] wbyte;

  assign off     = MY_ID - first_id_i;
  assign ge      = MY_ID >= first_id_i;
  assign in_bits = ge && (off < ID_W'(nbits_i));
  assign in_pair = ge && (off < ID_W'(nbits_i >> 1));
  assign in_byte = ge && (off < ID_W'(nbytes_i));
  assign id_hit  = ({2'b00, wdata_i[9:0]} == MY_ID);
  assign vis     = ds_i || sec_i || grp_o;   // group 0 hidden from non-secure
  assign ns_xf   = !ds_i && !sec_i;
  assign grp_ok  = ds_i || sec_i;
  assign nsac_ok = sec_i && !ds_i;
  assign wbit    = wdata_i[off[4:0]];
  assign wpair   = wdata_i[{off[3:0], 1'b0} +: 2];
  assign wbyte   = wdata_i[{off[1:0], 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_o  <= 1'b0;
      en_o   <= 1'b0;
      pend_o <= 1'b0;
      act_o  <= 1'b0;
      prio_o <= '0;
      cfg_o  <= '0;
      nsac_o <= '0;
    end else if (wr_i && vis) begin
      case (region_i)
        RG_GROUP:    if (grp_ok && in_bits) grp_o <= wbit;
        RG_EN_SET:   if (in_bits && wbit) en_o <= 1'b1;
        RG_EN_CLR:   if (in_bits && wbit) en_o <= 1'b0;
        RG_PD_SET:   if (in_bits && wbit) pend_o <= 1'b1;
        RG_PD_CLR:   if (in_bits && wbit) pend_o <= 1'b0;
        RG_AC_SET:   if (in_bits && wbit) act_o <= 1'b1;
        RG_AC_CLR:   if (in_bits && wbit) act_o <= 1'b0;
        RG_PRIO:     if (in_byte) prio_o <= ns_xf ? {1'b1, wbyte[7:1]} : wbyte;
        RG_CFG:      if (in_pair) cfg_o <= wpair;
        RG_NSAC:     if (in_pair && nsac_ok) nsac_o <= wpair;
        RG_SPEND_ID: if (id_hit) pend_o <= 1'b1;
        RG_CPEND_ID: if (id_hit) pend_o <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (vis) begin
      case (region_i)
        RG_GROUP:             if (grp_ok && in_bits) rdata_o[off[4:0]] = grp_o;
        RG_EN_SET, RG_EN_CLR: if (in_bits) rdata_o[off[4:0]] = en_o;
        RG_PD_SET, RG_PD_CLR: if (in_bits) rdata_o[off[4:0]] = pend_o;
        RG_AC_SET, RG_AC_CLR: if (in_bits) rdata_o[off[4:0]] = act_o;
        RG_PRIO:
          if (in_byte) rdata_o[{off[1:0], 3'b000} +: 8] = ns_xf ? {prio_o[6:0], 1'b0} : prio_o;
        RG_CFG:  if (in_pair) rdata_o[{off[3:0], 1'b0} +: 2] = cfg_o;
        RG_NSAC: if (in_pair && nsac_ok) rdata_o[{off[3:0], 1'b0} +: 2] = nsac_o;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_LINES = 96
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [11:0]                  addr_i,
  input  logic [2:0]                   size_i,
  input  logic [31:0]                  wdata_i,
  input  logic                         secure_i,
  output logic [31:0]                  rdata_o,
  output logic [NUM_LINES-33:0]        grp_o,
  output logic [NUM_LINES-33:0]        en_o,
  output logic [NUM_LINES-33:0]        pend_o,
  output logic [NUM_LINES-33:0]        act_o,
  output logic [8*(NUM_LINES-32)-1:0]  prio_o,
  output logic [2*(NUM_LINES-32)-1:0]  cfg_o,
  output logic [2*(NUM_LINES-32)-1:0]  nsac_o,
  output logic                         sec_dis_o,
  output logic                         en_grp0_o,
  output logic                         en_grp1ns_o,
  output logic                         en_grp1s_o
);
  localparam int FIRST_SPI   = 32;
  localparam int NUM_SPI     = NUM_LINES - FIRST_SPI;
  localparam int LINES_FIELD = (NUM_LINES + 31) / 32 - 1;
  localparam logic [31:0] TYPE_VAL = 32'h0003_0000 | 32'(LINES_FIELD & 31);

  region_e         region;
  logic [ID_W-1:0] first_id;
  logic [5:0]      nbits;
  logic [2:0]      nbytes;
  logic            wr;
  logic            ds_q, g0_q, g1ns_q, g1s_q;
  logic [31:0]     slice_rd [NUM_SPI];
  logic [31:0]     spi_rd, ctrl_rd, rd_mux;

  assign wr = req_i && we_i;

  irq_dist_decode u_decode (
    .addr_i    (addr_i),
    .region_o  (region),
    .first_id_o(first_id)
  );

  always_comb begin
    case (size_i)
      3'd1:    begin nbits = 6'd8;  nbytes = 3'd1; end
      3'd2:    begin nbits = 6'd16; nbytes = 3'd2; end
      default: begin nbits = 6'd32; nbytes = 3'd4; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q   <= 1'b0;
      g0_q   <= 1'b0;
      g1ns_q <= 1'b0;
      g1s_q  <= 1'b0;
    end else if (wr && region == RG_CTRL) begin
      if (secure_i || ds_q) begin
        g0_q  <= wdata_i[0];
        g1s_q <= wdata_i[2];
      end
      g1ns_q <= wdata_i[1];
      if (secure_i) ds_q <= wdata_i[6];
    end
  end

  for (genvar k = 0; k < NUM_SPI; k++) begin : g_irq
    irq_dist_slice #(.ID(FIRST_SPI + k)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr),
      .sec_i     (secure_i),
      .ds_i      (ds_q),
      .region_i  (region),
      .first_id_i(first_id),
      .nbits_i   (nbits),
      .nbytes_i  (nbytes),
      .wdata_i   (wdata_i),
      .grp_o     (grp_o[k]),
      .en_o      (en_o[k]),
      .pend_o    (pend_o[k]),
      .act_o     (act_o[k]),
      .prio_o    (prio_o[8*k +: 8]),
      .cfg_o     (cfg_o[2*k +: 2]),
      .nsac_o    (nsac_o[2*k +: 2]),
      .rdata_o   (slice_rd[k])
    );
  end

  always_comb begin
    spi_rd = '0;
    for (int k = 0; k < NUM_SPI; k++) spi_rd |= slice_rd[k];
  end

  always_comb begin
    if (secure_i || ds_q) ctrl_rd = {25'd0, ds_q, 1'b0, 1'b1, 1'b0, g1s_q, g1ns_q, g0_q};
    else                  ctrl_rd = {27'd0, 1'b1, 2'b00, g1ns_q, 1'b0};
  end

  always_comb begin
    case (region)
      RG_CTRL: rd_mux = ctrl_rd;
      RG_TYPE: rd_mux = TYPE_VAL;
      default: rd_mux = spi_rd;
    endcase
  end

  assign rdata_o     = (req_i && !we_i) ? rd_mux : 32'd0;
  assign sec_dis_o   = ds_q;
  assign en_grp0_o   = g0_q;
  assign en_grp1ns_o = g1ns_q;
  assign en_grp1s_o  = g1s_q;
endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int NUM_LINES = 96
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_i,
  input logic                        we_i,
  input logic [11:0]                 addr_i,
  input logic [2:0]                  size_i,
  input logic                        secure_i,
  input logic [31:0]                 rdata_o,
  input logic                        grp_first,
  input logic [NUM_LINES-33:0]       en_o,
  input logic [NUM_LINES-33:0]       pend_o,
  input logic [NUM_LINES-33:0]       act_o,
  input logic [8*(NUM_LINES-32)-1:0] prio_o,
  input logic                        ds_i
);
  localparam logic [31:0] EXP_TYPE = 32'h0003_0000 | 32'(((NUM_LINES + 31) / 32 - 1) & 31);

  logic rd, wr;
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  AST_ROUTE_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i == 12'h000 |-> rdata_o[4]); // R8
  AST_TYPE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i == 12'h004 |-> rdata_o == EXP_TYPE); // R2
  AST_LEGACY_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i[11:10] == 2'b10 |-> rdata_o == 32'd0); // R10
  AST_NSAC_NS_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && !secure_i && addr_i[11:8] == 4'hD |-> rdata_o == 32'd0); // R6
  AST_SET_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i[11:7] == 5'd2 |=> (($past(en_o) & ~en_o) == '0)); // R3
  AST_CLR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i[11:7] == 5'd3 |=> ((en_o & ~$past(en_o)) == '0)); // R3
  AST_NS_PRIO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !secure_i && !ds_i && addr_i == 12'h420 && size_i == 3'd1 && grp_first
    |=> prio_o[7]); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(en_o) && $stable(pend_o) && $stable(act_o) && $stable(prio_o)); // R12
endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .size_i   (size_i),
  .secure_i (secure_i),
  .rdata_o  (rdata_o),
  .grp_first(grp_o[0]),
  .en_o     (en_o),
  .pend_o   (pend_o),
  .act_o    (act_o),
  .prio_o   (prio_o),
  .ds_i     (ds_q)
);

// File: tb/irq_dist_regs_bench.sv
module irq_dist_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL  = 96;
  localparam int NS  = NL - 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, secure = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS-1:0] grp, en, pend, act;
  logic [8*NS-1:0] prio;
  logic [2*NS-1:0] cfg, nsac;
  logic sec_dis, eg0, eg1ns, eg1s;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_grp [1024], m_en [1024], m_pend [1024], m_act [1024];
  logic [7:0] m_prio [1024];
  logic [1:0] m_cfg [1024], m_nsac [1024];
  bit m_ds = 0, m_g0 = 0, m_g1ns = 0, m_g1s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_regs #(.NUM_LINES(NL)) u_irq_dist_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .secure_i(secure), .rdata_o(rdata),
    .grp_o(grp), .en_o(en), .pend_o(pend), .act_o(act), .prio_o(prio),
    .cfg_o(cfg), .nsac_o(nsac), .sec_dis_o(sec_dis), .en_grp0_o(eg0),
    .en_grp1ns_o(eg1ns), .en_grp1s_o(eg1s)
  );

  function automatic bit vis(int id, bit sec);
    return id >= 32 && id < NL && (m_ds || sec || m_grp[id]);
  endfunction

  function automatic logic [31:0] m_read(int a, int sz, bit sec);
    logic [31:0] r = '0;
    logic [7:0] p;
    int id, first;
    if (a == 0) begin
      if (sec || m_ds) r = (32'(m_ds) << 6) | 32'h10 | (32'(m_g1s) << 2) | (32'(m_g1ns) << 1) | 32'(m_g0);
      else r = 32'h10 | (32'(m_g1ns) << 1);
    end else if (a == 4) r = 32'h30000 | 32'((NL + 31) / 32 - 1);
    else if (a >= 'h80 && a < 'h400) begin
      first = (a % 128) * 8;
      for (int i = 0; i < sz * 8; i++) begin
        id = first + i;
        if (vis(id, sec))
          case (a / 128)
            1: if (sec || m_ds) r[i] = m_grp[id];
            2, 3: r[i] = m_en[id];
            4, 5: r[i] = m_pend[id];
            default: r[i] = m_act[id];
          endcase
      end
    end else if (a >= 'h400 && a < 'h800) begin
      for (int i = 0; i < sz; i++) begin
        id = a - 'h400 + i;
        if (vis(id, sec)) begin
          p = m_prio[id];
          if (!sec && !m_ds) p = {p[6:0], 1'b0};
          r[8*i +: 8] = p;
        end
      end
    end else if (a >= 'hC00 && a < 'hE00) begin
      first = (a % 256) * 4;
      for (int i = 0; i < sz * 4; i++) begin
        id = first + i;
        if (vis(id, sec)) begin
          if (a < 'hD00) r[2*i +: 2] = m_cfg[id];
          else if (sec && !m_ds) r[2*i +: 2] = m_nsac[id];
        end
      end
    end
    return r;
  endfunction

  task automatic m_write(int a, int sz, logic [31:0] d, bit sec);
    int id, first;
    logic [7:0] v;
    if (a == 0) begin
      if (sec || m_ds) begin m_g0 = d[0]; m_g1s = d[2]; end
      m_g1ns = d[1];
      if (sec) m_ds = d[6];
    end else if (a == 'h10 || a == 'h14) begin
      id = int'(d[9:0]);
      if (vis(id, sec)) m_pend[id] = (a == 'h10);
    end else if (a >= 'h80 && a < 'h400) begin
      first = (a % 128) * 8;
      for (int i = 0; i < sz * 8; i++) begin
        id = first + i;
        if (vis(id, sec))
          case (a / 128)
            1: if (sec || m_ds) m_grp[id] = d[i];
            2: if (d[i]) m_en[id] = 1;
            3: if (d[i]) m_en[id] = 0;
            4: if (d[i]) m_pend[id] = 1;
            5: if (d[i]) m_pend[id] = 0;
            6: if (d[i]) m_act[id] = 1;
            default: if (d[i]) m_act[id] = 0;
          endcase
      end
    end else if (a >= 'h400 && a < 'h800) begin
      for (int i = 0; i < sz; i++) begin
        id = a - 'h400 + i;
        v = d[8*i +: 8];
        if (!sec && !m_ds) v = 8'h80 | (v >> 1);
        if (vis(id, sec)) m_prio[id] = v;
      end
    end else if (a >= 'hC00 && a < 'hE00) begin
      first = (a % 256) * 4;
      for (int i = 0; i < sz * 4; i++) begin
        id = first + i;
        if (vis(id, sec)) begin
          if (a < 'hD00) m_cfg[id] = d[2*i +: 2];
          else if (sec && !m_ds) m_nsac[id] = d[2*i +: 2];
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int sz, logic [31:0] d, bit sec);
    @(negedge clk);
    req = 1; we = 1; addr = 12'(a); size = 3'(sz); wdata = d; secure = sec;
    @(posedge clk);
    m_write(a, sz, d, sec);
  endtask

  task automatic rd(int a, int sz, bit sec, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = 12'(a); size = 3'(sz); wdata = '0; secure = sec;
    #1;
    chk(tag, rdata, m_read(a, sz, sec));
  endtask

  // every-cycle comparison of all state vectors against the model (R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NS-1:0] eg, ee, ep, ea;
      logic [8*NS-1:0] epr;
      logic [2*NS-1:0] ec, en2;
      for (int k = 0; k < NS; k++) begin
        eg[k] = m_grp[32+k]; ee[k] = m_en[32+k]; ep[k] = m_pend[32+k]; ea[k] = m_act[32+k];
        epr[8*k +: 8] = m_prio[32+k]; ec[2*k +: 2] = m_cfg[32+k]; en2[2*k +: 2] = m_nsac[32+k];
      end
      n_tests++;
      if (grp !== eg || en !== ee || pend !== ep || act !== ea || prio !== epr ||
          cfg !== ec || nsac !== en2 ||
          {sec_dis, eg0, eg1ns, eg1s} !== {m_ds, m_g0, m_g1ns, m_g1s}) begin
        n_fail++;
        $display("FAIL R12 state actual en=%h pend=%h act=%h expected en=%h pend=%h act=%h",
                 en, pend, act, ee, ep, ea);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      m_grp[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
      m_prio[i] = '0; m_cfg[i] = '0; m_nsac[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd('h000, 4, 1, "R1 ctrl");
    rd('h104, 4, 1, "R1 enable");
    rd('h420, 4, 1, "R1 prio");
    // R2 type register, write ignored
    rd('h004, 4, 1, "R2 type");
    wr('h004, 4, 32'hFFFF_FFFF, 1);
    rd('h004, 4, 0, "R2 type after write");
    // R7 group register
    wr('h084, 4, 32'hFFFF_0000, 1);
    rd('h084, 4, 1, "R7 group secure");
    rd('h084, 4, 0, "R7 group ns raz");
    wr('h084, 4, 32'h0000_FFFF, 0);
    rd('h084, 4, 1, "R7 group ns wi");
    // R3 set/clear
    wr('h104, 4, 32'h0000_00F0, 1);
    wr('h104, 4, 32'h0000_0003, 1);
    wr('h104, 4, 32'h0, 1);
    wr('h184, 4, 32'h0000_0011, 1);
    rd('h104, 4, 1, "R3 enable set/clear");
    rd('h184, 4, 1, "R3 enable via clear reg");
    wr('h204, 4, 32'hA5A5_0F0F, 1);
    wr('h284, 4, 32'h0000_0F00, 1);
    rd('h204, 4, 1, "R3 pending");
    wr('h304, 4, 32'h1234_5678, 1);
    wr('h384, 4, 32'h0000_0070, 1);
    rd('h384, 4, 1, "R3 active");
    wr('h108, 1, 32'hFFFF_FFFF, 1);
    rd('h108, 4, 1, "R3 byte count 1");
    wr('h188, 2, 32'hFFFF_FFFF, 1);
    rd('h108, 4, 1, "R3 byte count 2");
    // R7 hiding of group-0 interrupts
    wr('h104, 4, 32'hFFFF_FFFF, 0);
    rd('h104, 4, 1, "R7 ns set only group1");
    rd('h104, 4, 0, "R7 ns view");
    // R4 priority
    wr('h420, 4, 32'h4433_2211, 1);
    wr('h425, 1, 32'hFFFF_FFAB, 1);
    wr('h426, 2, 32'hFFFF_CDEF, 1);
    rd('h420, 4, 1, "R4 prio word");
    rd('h424, 4, 1, "R4 prio partial");
    // R5 non-secure priority view
    wr('h430, 1, 32'h40, 0);
    rd('h430, 1, 1, "R5 ns write stored");
    rd('h430, 1, 0, "R5 ns read shifted");
    wr('h420, 1, 32'h77, 0);
    rd('h420, 1, 1, "R7 ns prio group0 ignored");
    // R6 config and access control
    wr('hC08, 4, 32'h0000_000F, 1);
    wr('hC0A, 1, 32'h0000_00E4, 1);
    rd('hC08, 4, 1, "R6 cfg");
    rd('hC0C, 4, 0, "R6 cfg ns");
    wr('hD08, 4, 32'h0000_0009, 1);
    wr('hD08, 4, 32'hFFFF_FFFF, 0);
    rd('hD08, 4, 1, "R6 nsac secure");
    rd('hD08, 4, 0, "R6 nsac ns raz");
    // R9 single-id pending
    wr('h010, 4, 32'd40, 1);
    wr('h010, 4, 32'hFFFF_FC29, 1);
    rd('h204, 4, 1, "R9 single set");
    wr('h014, 4, 32'd40, 1);
    rd('h204, 4, 1, "R9 single clear");
    rd('h010, 4, 1, "R9 single raz");
    wr('h010, 4, 32'h3A5, 1);
    // R10 RAZ/WI regions
    wr('h820, 4, 32'hFFFF_FFFF, 1);
    rd('h820, 4, 1, "R10 legacy");
    rd('hF10, 4, 1, "R10 sgi pend");
    rd('h008, 4, 1, "R10 hole");
    wr('hE80, 4, 32'hFFFF_FFFF, 1);
    // R11 out of range IDs
    wr('h100, 4, 32'hFFFF_FFFF, 1);
    wr('h10C, 4, 32'hFFFF_FFFF, 1);
    rd('h100, 4, 1, "R11 ids below 32");
    rd('h10C, 4, 1, "R11 ids beyond lines");
    wr('h460, 4, 32'h1122_3344, 1);
    rd('h460, 4, 1, "R11 prio beyond lines");
    // R8 control register
    wr('h000, 4, 32'h0000_0007, 1);
    rd('h000, 4, 1, "R8 ctrl secure");
    wr('h000, 4, 32'h0, 0);
    rd('h000, 4, 1, "R8 ctrl ns write");
    rd('h000, 4, 0, "R8 ctrl ns view");
    wr('h000, 4, 32'h0000_0047, 1);
    rd('h000, 4, 0, "R8 ctrl security disabled");
    // with security disabled
    wr('h420, 1, 32'h40, 0);
    rd('h420, 1, 0, "R5 raw when disabled");
    rd('h084, 4, 0, "R7 group visible when disabled");
    rd('hD08, 4, 1, "R6 nsac raz when disabled");
    @(negedge clk);
    req = 0; we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule